// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block keeps track of instructions that an out-of-order core has dispatched and not yet retired. It holds them in a circular ring of entries. A dispatch reserves one or more consecutive entries for a single instruction and hands back a token, which is the index of the first reserved entry. The execution units later report completion by presenting that token on the execute port, and the block marks the instruction as done.

Each cycle the controller walks forward from the oldest instruction. It retires every consecutive completed instruction until it reaches one that is still pending or hits the per-cycle retire limit. For each retirement it raises one lane of the retire output, carrying the instruction's tag, and it returns the instruction's entries to the free pool.

The dispatch port is a valid/ready stream. `disp_ready` is computed from the current free count and the requested size on `disp_slots`, so it may change with the payload. A transfer happens only in a cycle where both `disp_valid` and `disp_ready` are high. When ready is low the producer holds its request, and nothing inside the block changes because of it. The retire output has no back-pressure: the owning pipeline must take every lane that is valid in the cycle it appears. The execute port is a plain strobe.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: `empty`=1, `free_cnt`=DEPTH, no retire lane is valid, and a one-entry request sees `disp_ready`=1.
- R2: The size an instruction reserves is its requested slot count clamped to the range 1..DEPTH. A request of 0 reserves one entry, and a request above DEPTH reserves all DEPTH entries.
- R3: `disp_ready` is 1 exactly when `free_cnt` is greater than or equal to the clamped size, so equality passes. A request presented while ready is 0 changes neither the free count nor the next token.
- R4: An accepted dispatch returns on `disp_token` the current tail index, with bit TOK_W-1 equal to 0. The tail then advances by the clamped size, modulo DEPTH.
- R5: Instructions retire strictly in program order. A completed instruction that is not the oldest stays in flight until every older instruction has retired.
- R6: At most MAX_RETIRE instructions retire per cycle (0 means no limit). Lane 0 carries the oldest, the valid lanes form a contiguous group starting at lane 0, and `ret_tag` lane i occupies bits [8i+7:8i] with the default TAG_W of 8.
- R7: A retire appears on the retire lanes in the cycle after its completion strobe is sampled, provided the instruction is then the oldest. The clock edge that ends that cycle returns its reserved entries to `free_cnt`.
- R8: An execute strobe whose token has its top bit set, including the all-ones "untracked" token, is ignored and marks no instruction complete.
- R9: When a dispatch and retirements share a cycle, `free_cnt` changes by the retired entries minus the dispatched entries.
- R10: `empty` is 1 exactly when `free_cnt` equals DEPTH, and no retire lane is ever valid while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request valid |
| disp_ready | output | 1 | Enough free entries for the presented request |
| disp_tag | input | TAG_W | Instruction tag stored with the dispatch |
| disp_slots | input | REQ_W | Requested entry count (clamped) |
| disp_token | output | TOK_W | Token assigned to the presented request |
| exec_valid | input | 1 | Execution-complete strobe |
| exec_token | input | TOK_W | Token of the completed instruction |
| ret_valid | output | LANES | Per-lane retire valid, lane 0 oldest |
| ret_tag | output | LANES*TAG_W | Tags of the retiring instructions |
| free_cnt | output | CNT_W | Free entries |
| empty | output | 1 | No instruction in flight |

## Verification
Dispatch and retirement can fall in the same cycle. The bench provokes this by raising the completion strobe for the oldest instruction and then, on the next cycle, presenting a new dispatch while that retire lane is visible. It checks that the new token is the expected tail, that the retire carries the right tag, and that the free count afterwards moves by exactly the retired size minus the dispatched size. Completion of a younger instruction before an older one is checked separately: it must not retire on its own, and it must then retire alongside the older one, in order and within the lane limit.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  // Ring-index addition: a + b folded once into the range [0, depth).
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rcu_norm.sv
module rcu_norm #(
  parameter int DEPTH = 16,
  parameter int REQ_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [REQ_W-1:0] req,
  output logic [CNT_W-1:0] size
);
  // Clamp requested entries into 1..DEPTH.
  always_comb begin
    if (req == '0)
      size = CNT_W'(1);
    else if (32'(req) > DEPTH)
      size = CNT_W'(DEPTH);
    else
      size = CNT_W'(req);
  end
endmodule

// File: rtl/rcu_token_store.sv
module rcu_token_store #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TOK_W = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [CNT_W-1:0]              wr_size,
  input  logic                          done_valid,
  input  logic [TOK_W-1:0]              done_token,
  input  logic [DEPTH-1:0]              retire_mask,
  output logic [DEPTH-1:0]              done_vec,
  output logic [DEPTH-1:0][TAG_W-1:0]   tags,
  output logic [DEPTH-1:0][CNT_W-1:0]   sizes
);
  logic [DEPTH-1:0] set_mask;
  logic [DEPTH-1:0] done_next;

  // Token decode: only tokens with top bit clear can match an entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign set_mask[g] = done_valid && (done_token == TOK_W'(g));
  end

  always_comb begin
    done_next = (done_vec & ~retire_mask) | set_mask;
    if (wr_en) done_next[wr_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) done_vec <= '0;
    else     done_vec <= done_next;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[wr_idx]  <= wr_tag;
      sizes[wr_idx] <= wr_size;
    end
  end

  // A freshly written entry always starts as not complete.
  p_fresh_pending_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !done_vec[$past(wr_idx)]);
endmodule

// File: rtl/rcu_retire_scan.sv
module rcu_retire_scan #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int LANES = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [IDX_W-1:0]              head,
  input  logic [CNT_W-1:0]              used,
  input  logic [DEPTH-1:0]              done_vec,
  input  logic [DEPTH-1:0][TAG_W-1:0]   tags,
  input  logic [DEPTH-1:0][CNT_W-1:0]   sizes,
  output logic [LANES-1:0]              ret_valid,
  output logic [LANES*TAG_W-1:0]        ret_tag,
  output logic [DEPTH-1:0]              retire_mask,
  output logic [IDX_W-1:0]              head_next,
  output logic [CNT_W-1:0]              ret_total
);
  always_comb begin
    logic [IDX_W-1:0] p;
    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] n;
    logic             go;
    p = head;
    left = used;
    n = '0;
    go = 1'b1;
    ret_total = '0;
    ret_valid = '0;
    ret_tag = '0;
    retire_mask = '0;
    for (int i = 0; i < LANES; i++) begin
      if (go && left != '0 && done_vec[p]) begin
        ret_valid[i] = 1'b1;
        ret_tag[i*TAG_W +: TAG_W] = tags[p];
        retire_mask[p] = 1'b1;
        n = sizes[p];
        ret_total = ret_total + n;
        left = left - n;
        p = IDX_W'(rcu_pkg::wrap_add(32'(p), 32'(n), DEPTH));
      end else begin
        go = 1'b0;
      end
    end
    head_next = p;
  end

  // Valid lanes are a contiguous group starting at lane 0.
  p_lanes_contig_r6: assert property (@(posedge clk) disable iff (rst)
    ((ret_valid + LANES'(1)) & ret_valid) == '0);
  p_within_used_r7: assert property (@(posedge clk) disable iff (rst)
    ret_total <= used);
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl #(
  parameter int DEPTH      = 16,
  parameter int TAG_W      = 8,
  parameter int REQ_W      = 6,
  parameter int MAX_RETIRE = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TOK_W = IDX_W + 1,
  localparam int LANES = (MAX_RETIRE == 0 || MAX_RETIRE > DEPTH) ? DEPTH : MAX_RETIRE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [TAG_W-1:0]       disp_tag,
  input  logic [REQ_W-1:0]       disp_slots,
  output logic [TOK_W-1:0]       disp_token,
  input  logic                   exec_valid,
  input  logic [TOK_W-1:0]       exec_token,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*TAG_W-1:0] ret_tag,
  output logic [CNT_W-1:0]       free_cnt,
  output logic                   empty
);
  logic [IDX_W-1:0]            head_q, tail_q, head_next;
  logic [CNT_W-1:0]            free_q, size, ret_total, used;
  logic                        fire;
  logic [DEPTH-1:0]            done_vec, retire_mask;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [DEPTH-1:0][CNT_W-1:0] sizes;

  rcu_norm #(.DEPTH(DEPTH), .REQ_W(REQ_W)) u_norm (
    .req(disp_slots), .size(size));

  assign disp_ready = (free_q >= size);
  assign fire       = disp_valid && disp_ready;
  assign disp_token = {1'b0, tail_q};
  assign used       = CNT_W'(DEPTH) - free_q;
  assign free_cnt   = free_q;
  assign empty      = (free_q == CNT_W'(DEPTH));

  rcu_token_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(fire), .wr_idx(tail_q), .wr_tag(disp_tag), .wr_size(size),
    .done_valid(exec_valid), .done_token(exec_token),
    .retire_mask(retire_mask),
    .done_vec(done_vec), .tags(tags), .sizes(sizes));

  rcu_retire_scan #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LANES(LANES)) u_scan (
    .clk(clk), .rst(rst),
    .head(head_q), .used(used), .done_vec(done_vec), .tags(tags), .sizes(sizes),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .retire_mask(retire_mask),
    .head_next(head_next), .ret_total(ret_total));

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      free_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= head_next;
      if (fire) tail_q <= IDX_W'(rcu_pkg::wrap_add(32'(tail_q), 32'(size), DEPTH));
      free_q <= free_q - (fire ? size : CNT_W'(0)) + ret_total;
    end
  end

  p_free_bound_r9: assert property (@(posedge clk) disable iff (rst)
    free_q <= CNT_W'(DEPTH));
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> $stable(tail_q));
  p_head_done_r5: assert property (@(posedge clk) disable iff (rst)
    ret_valid[0] |-> done_vec[head_q]);
  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    empty |-> (ret_valid == '0));
  p_untracked_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_valid && exec_token[TOK_W-1] && !fire && ret_valid == '0) |=> $stable(done_vec));
endmodule

// File: tb/rob_retire_ctrl_tb.sv
module rob_retire_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int TAG_W = 8;
  localparam int REQ_W = 6;
  localparam int LANES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0;
  logic disp_ready;
  logic [TAG_W-1:0] disp_tag = '0;
  logic [REQ_W-1:0] disp_slots = '0;
  logic [4:0] disp_token;
  logic exec_valid = 1'b0;
  logic [4:0] exec_token = '0;
  logic [LANES-1:0] ret_valid;
  logic [LANES*TAG_W-1:0] ret_tag;
  logic [4:0] free_cnt;
  logic empty;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rob_retire_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REQ_W(REQ_W), .MAX_RETIRE(2)) u_dut (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_slots(disp_slots), .disp_token(disp_token),
    .exec_valid(exec_valid), .exec_token(exec_token),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .free_cnt(free_cnt), .empty(empty));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // Present a request for one cycle; report ready and token seen before the edge.
  task automatic dispatch(input logic [7:0] tag, input int slots, output int rdy, output int tok);
    @(negedge clk);
    disp_valid = 1'b1;
    disp_tag = tag;
    disp_slots = REQ_W'(slots);
    #1;
    rdy = int'(disp_ready);
    tok = int'(disp_token);
    @(negedge clk);
    disp_valid = 1'b0;
    #1;
  endtask

  // Pulse completion; return one cycle later, when its retire becomes visible.
  task automatic complete(input int tok);
    @(negedge clk);
    exec_valid = 1'b1;
    exec_token = 5'(tok);
    @(negedge clk);
    exec_valid = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    disp_slots = REQ_W'(1);
    #1;
    chk("R1", "empty after reset", int'(empty), 1);
    chk("R1", "free after reset", int'(free_cnt), DEPTH);
    chk("R1", "no retire after reset", int'(ret_valid), 0);
    chk("R1", "ready after reset", int'(disp_ready), 1);
  endtask

  task automatic t_clamp();
    int rdy, tok;
    dispatch(8'h11, 0, rdy, tok);
    chk("R2", "zero request accepted", rdy, 1);
    chk("R4", "first token", tok, 0);
    chk("R2", "zero request takes one entry", int'(free_cnt), 15);
    dispatch(8'h22, 40, rdy, tok);
    chk("R3", "oversize stalls with 15 free", rdy, 0);
    chk("R3", "stall leaves free count", int'(free_cnt), 15);
    complete(0);
    chk("R7", "retire lane 0 valid", int'(ret_valid), 1);
    chk("R7", "retire tag", int'(ret_tag[7:0]), 8'h11);
    step();
    chk("R7", "entry returned", int'(free_cnt), 16);
    chk("R10", "empty again", int'(empty), 1);
    dispatch(8'h22, 40, rdy, tok);
    chk("R3", "oversize accepted when all free", rdy, 1);
    chk("R4", "token after stalled request", tok, 1);
    chk("R2", "oversize takes DEPTH entries", int'(free_cnt), 0);
    chk("R10", "not empty when full", int'(empty), 0);
    dispatch(8'h33, 1, rdy, tok);
    chk("R3", "full buffer stalls", rdy, 0);
    complete(1);
    chk("R7", "full-size retire tag", int'(ret_tag[7:0]), 8'h22);
    step();
    chk("R7", "all entries returned", int'(free_cnt), 16);
  endtask

  task automatic t_order();
    int rdy, tok;
    dispatch(8'hA1, 2, rdy, tok);
    chk("R4", "token A wraps to tail 1", tok, 1);
    dispatch(8'hB2, 3, rdy, tok);
    chk("R4", "token B", tok, 3);
    dispatch(8'hC3, 1, rdy, tok);
    chk("R4", "token C", tok, 6);
    chk("R2", "free after three", int'(free_cnt), 10);
    complete(6);
    chk("R5", "young C held", int'(ret_valid), 0);
    complete(3);
    chk("R5", "young B held", int'(ret_valid), 0);
    chk("R5", "free unchanged", int'(free_cnt), 10);
    complete(1);
    chk("R6", "two lanes retire", int'(ret_valid), 3);
    chk("R6", "lane 0 oldest", int'(ret_tag[7:0]), 8'hA1);
    chk("R6", "lane 1 next", int'(ret_tag[15:8]), 8'hB2);
    step();
    chk("R6", "limit defers C", int'(ret_valid), 1);
    chk("R6", "C on lane 0", int'(ret_tag[7:0]), 8'hC3);
    chk("R7", "A and B entries freed", int'(free_cnt), 15);
    step();
    chk("R7", "C entry freed", int'(free_cnt), 16);
  endtask

  task automatic t_concurrent();
    int rdy, tok;
    dispatch(8'hD4, 4, rdy, tok);
    chk("R4", "token D", tok, 7);
    chk("R9", "free after D", int'(free_cnt), 12);
    @(negedge clk);
    exec_valid = 1'b1;
    exec_token = 5'd7;
    @(negedge clk);
    exec_valid = 1'b0;
    disp_valid = 1'b1;
    disp_tag = 8'hE5;
    disp_slots = REQ_W'(2);
    #1;
    chk("R9", "D retiring", int'(ret_valid), 1);
    chk("R9", "D tag", int'(ret_tag[7:0]), 8'hD4);
    chk("R9", "E ready", int'(disp_ready), 1);
    chk("R9", "E token", int'(disp_token), 11);
    @(negedge clk);
    disp_valid = 1'b0;
    #1;
    chk("R9", "net free", int'(free_cnt), 14);
    complete(11);
    chk("R9", "E retires", int'(ret_tag[7:0]), 8'hE5);
    step();
    chk("R9", "all free", int'(free_cnt), 16);
  endtask

  task automatic t_untracked();
    int rdy, tok;
    do_reset();
    dispatch(8'hF6, 15, rdy, tok);
    chk("R4", "token F", tok, 0);
    disp_slots = REQ_W'(2);
    #1;
    chk("R3", "two entries stall with 1 free", int'(disp_ready), 0);
    dispatch(8'h07, 1, rdy, tok);
    chk("R3", "exact fit accepted", rdy, 1);
    chk("R4", "token G at last slot", tok, 15);
    complete(31);
    chk("R8", "untracked marks nothing", int'(ret_valid), 0);
    complete(0);
    chk("R8", "only F retires", int'(ret_valid), 1);
    step();
    chk("R8", "G still pending", int'(ret_valid), 0);
    chk("R8", "one entry in use", int'(free_cnt), 15);
    complete(15);
    chk("R7", "G retires", int'(ret_tag[7:0]), 8'h07);
    step();
    chk("R10", "empty at end", int'(empty), 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_clamp();
    t_order();
    t_concurrent();
    t_untracked();
    finish_run();
  end
endmodule